// File: doc/BRIEF.md
# Configuration Access Address Decoder

This block sits between the configuration-request source of a root complex and a memory-mapped window that holds configuration space. A request names a bus, a device/function and a byte offset. The block decides whether the request may reach the window and, if so, turns it into one memory access at the window base plus a packed routing offset. The bus number sits at bit 20 and up, the device/function at bit 12 and up, and the byte offset in the low twelve bits.

A request is refused when the window is not present or not enabled. It is also refused when it targets any device/function other than 0 on the root bus, or targets a bus other than the root bus while the link-up input is low. A refused read completes at once with all ones. A refused write completes and changes nothing. A small register set holds the enable bit, a window size field that also reports the last bus number, and the 64-bit window base split into two 32-bit words. A read-only capability word reports that the window exists.

The block handles one request at a time. The memory side is a valid/ready port that may stall for any number of cycles.

Top module: `cfg_addr_decoder`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_valid are 0, the control word (reg_addr 1) reads 0x000C0000, and both base words read 0.
- R2: The capability word at reg_addr 0 reads 0x00000001, and writing to it has no effect.
- R3: An accepted valid request drives mem_addr = {base_hi, base_lo} + ((bus << 20) | (devfn << 12) | offset), where the offset is 12 bits wide.
- R4: On the root bus (bus 0), a request with any device/function other than 0 is refused and never raises mem_valid.
- R5: A request to a bus other than the root bus is refused while link_up is 0 when the request is accepted.
- R6: While the enable bit (bit 0 of the control word) is 0, every request is refused.
- R7: A refused request raises rsp_valid for exactly one cycle, in the cycle after acceptance, with rsp_data = 0xFFFFFFFF, and does not raise mem_valid.
- R8: A refused write reaches no memory location: a later valid read of the same address returns the old contents.
- R9: A valid request holds mem_valid, mem_addr, mem_write and mem_wdata steady until mem_ready. rsp_valid follows for one cycle after the handshake, with the read data (or 0 for a write).
- R10: The control word keeps only bit 0 (enable) and bits 20:16 (window size, which is also the last bus number). All other bits read 0.
- R11: The base address is written and read as two 32-bit words: the low word at reg_addr 2 and the high word at reg_addr 3.
- R12: req_ready is 0 from acceptance until the cycle after the response, so only one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link status; gates requests to buses other than the root bus |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 capability, 1 control, 2 base low, 3 base high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_off | input | 12 | Byte offset into the function's space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Read data, all ones when refused |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts the access |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The bench sends requests to the root bus with device/function values other than 0. A decoder that only checks the device number, or that ignores the root-bus rule, would leak these to memory. It also sends requests to other buses with the link down, then repeats them with the link up. A decoder that samples link status at the wrong moment, or drops a refused write on the floor only in part, would change memory here, and the bench reads the same address back to catch it. Requests use the extreme bus, device/function and offset values with a base that carries into the high word, so a shift by the wrong amount, an OR where an add is needed, or a lost carry shows up as a wrong address. A stalled memory checks that the request is held steady, and the control-word tests catch stray bits and a wrong reset size.

// File: rtl/cfg_dec_pkg.sv
// Shared definitions for the configuration access decoder.
// Assumes 32-bit register words; field positions are fixed here.
package cfg_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_CAP     = 2'd0;
    localparam logic [1:0] SEL_CTRL    = 2'd1;
    localparam logic [1:0] SEL_BASE_LO = 2'd2;
    localparam logic [1:0] SEL_BASE_HI = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SIZE_LSB = 16;
    localparam int CTRL_SIZE_W   = 5;

endpackage

// File: rtl/cfg_win_regs.sv
// Control register set for the configuration window.
// Holds the enable bit, the size field (last bus number) and the 64-bit
// base as two words. The capability word is read-only.
// Assumes DATA_W >= CTRL_SIZE_LSB + CTRL_SIZE_W.
module cfg_win_regs
    import cfg_dec_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int SIZE_DEFAULT = 12,
    parameter bit CAP_PRESENT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                win_present,
    output logic                win_enable,
    output logic [2*DATA_W-1:0] win_base
);

    logic                   en_q;
    logic [CTRL_SIZE_W-1:0] size_q;
    logic [DATA_W-1:0]      base_lo_q;
    logic [DATA_W-1:0]      base_hi_q;

    // Register writes; only the defined control fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            size_q    <= CTRL_SIZE_W'(SIZE_DEFAULT);
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                SEL_CTRL: begin
                    en_q   <= reg_wdata[CTRL_EN_BIT];
                    size_q <= reg_wdata[CTRL_SIZE_LSB +: CTRL_SIZE_W];
                end
                SEL_BASE_LO: base_lo_q <= reg_wdata;
                SEL_BASE_HI: base_hi_q <= reg_wdata;
                default:     ;
            endcase
        end
    end

    // Read mux; undefined control bits read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CAP:     reg_rdata[0] = CAP_PRESENT;
            SEL_CTRL: begin
                reg_rdata[CTRL_EN_BIT] = en_q;
                reg_rdata[CTRL_SIZE_LSB +: CTRL_SIZE_W] = size_q;
            end
            SEL_BASE_LO: reg_rdata = base_lo_q;
            SEL_BASE_HI: reg_rdata = base_hi_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign win_present = CAP_PRESENT;
    assign win_enable  = en_q;
    assign win_base    = {base_hi_q, base_lo_q};

    // R10: a control write lands in the size field on the next cycle.
    assert_size_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SEL_CTRL) |=>
            (size_q == $past(reg_wdata[CTRL_SIZE_LSB +: CTRL_SIZE_W])));

endmodule

// File: rtl/cfg_req_filter.sv
// Decides whether a configuration request may reach the window.
// Purely combinational; link status is taken as presented.
module cfg_req_filter #(
    parameter int BUS_W    = 8,
    parameter int DEVFN_W  = 8,
    parameter int ROOT_BUS = 0
) (
    input  logic               win_present,
    input  logic               win_enable,
    input  logic               link_up,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    output logic               req_ok
);

    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic target_ok;

    // Root bus: function 0 only; other buses: need a live link.
    always_comb begin
        if (bus == ROOT) target_ok = (devfn == '0);
        else             target_ok = link_up;
    end

    assign req_ok = win_present && win_enable && target_ok;

endmodule

// File: rtl/cfg_addr_calc.sv
// Builds the window byte address from base, bus, devfn and offset.
// Assumes the packed routing fields do not overlap.
module cfg_addr_calc #(
    parameter int BUS_W   = 8,
    parameter int DEVFN_W = 8,
    parameter int OFF_W   = 12,
    parameter int ADDR_W  = 64
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   off,
    output logic [ADDR_W-1:0]  addr
);

    localparam int DEVFN_SHIFT = OFF_W;
    localparam int BUS_SHIFT   = OFF_W + DEVFN_W;

    logic [ADDR_W-1:0] route;

    // Pack routing fields, then add to the base with a full carry.
    always_comb begin
        route = (ADDR_W'(bus) << BUS_SHIFT)
              | (ADDR_W'(devfn) << DEVFN_SHIFT)
              | ADDR_W'(off);
        addr  = base + route;
    end

endmodule

// File: rtl/cfg_addr_decoder.sv
// Configuration access decoder top. It accepts one request at a time,
// filters it, and issues a single window access or a refusal response.
// Assumes the memory side returns read data together with mem_ready.
module cfg_addr_decoder
    import cfg_dec_pkg::*;
#(
    parameter int BUS_W        = 8,
    parameter int DEVFN_W      = 8,
    parameter int OFF_W        = 12,
    parameter int DATA_W       = 32,
    parameter int ROOT_BUS     = 0,
    parameter int SIZE_DEFAULT = 12,
    parameter bit CAP_PRESENT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_up,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [BUS_W-1:0]    req_bus,
    input  logic [DEVFN_W-1:0]  req_devfn,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_write,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic              win_present;
    logic              win_enable;
    logic [ADDR_W-1:0] win_base;
    logic              req_ok;
    logic [ADDR_W-1:0] calc_addr;

    seq_state_e        state_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rsp_q;

    cfg_win_regs #(
        .DATA_W      (DATA_W),
        .SIZE_DEFAULT(SIZE_DEFAULT),
        .CAP_PRESENT (CAP_PRESENT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .win_present(win_present),
        .win_enable (win_enable),
        .win_base   (win_base)
    );

    cfg_req_filter #(
        .BUS_W   (BUS_W),
        .DEVFN_W (DEVFN_W),
        .ROOT_BUS(ROOT_BUS)
    ) u_filter (
        .win_present(win_present),
        .win_enable (win_enable),
        .link_up    (link_up),
        .bus        (req_bus),
        .devfn      (req_devfn),
        .req_ok     (req_ok)
    );

    cfg_addr_calc #(
        .BUS_W  (BUS_W),
        .DEVFN_W(DEVFN_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_calc (
        .base (win_base),
        .bus  (req_bus),
        .devfn(req_devfn),
        .off  (req_off),
        .addr (calc_addr)
    );

    // Request sequencer: accept, access or refuse, respond, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        addr_q  <= calc_addr;
                        wdata_q <= req_wdata;
                        if (req_ok) begin
                            state_q <= ST_MEM;
                        end else begin
                            rsp_q   <= '1;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_ready) begin
                        rsp_q   <= wr_q ? '0 : mem_rdata;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q == ST_MEM);
    assign rsp_valid = (state_q == ST_RESP);
    assign mem_write = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rsp_data  = rsp_q;

    // R7: a refused request answers next cycle with all ones and no access.
    assert_refuse_allones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_ok) |=>
            (rsp_valid && rsp_data == '1 && !mem_valid));

    // R7: the completion pulse lasts one cycle.
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: a stalled access keeps its fields steady.
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    // R4: non-zero device/function on the root bus never reaches memory.
    assert_root_devfn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bus == ROOT && req_devfn != '0) |=> !mem_valid);

    // R5: downstream buses are not accessed while the link is down.
    assert_link_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bus != ROOT && !link_up) |=> !mem_valid);

endmodule

// File: tb/sim_cfg_addr_decoder.sv
`timescale 1ns / 100ps
module sim_cfg_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic [63:0] base = 64'h0000_0012_FFF0_0000;
    logic [31:0] mem_model [logic [63:0]];

    always #2.5 clk = ~clk;

    cfg_addr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_get(input logic [63:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return a[31:0] ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [63:0] exp_addr(input logic [7:0] b, input logic [7:0] d,
                                             input logic [11:0] o);
        return base + {36'd0, b, d, o};
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Issue one request and serve the memory side with a given stall.
    task automatic do_access(input logic we, input logic [7:0] b, input logic [7:0] d,
                             input logic [11:0] o, input logic [31:0] wd, input int stall,
                             output logic [31:0] rd, output logic saw,
                             output logic [63:0] seen_a, output logic [31:0] seen_wd,
                             output int cyc, output logic hs_ok);
        @(negedge clk);
        req_write = we; req_bus = b; req_devfn = d; req_off = o; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; saw = 1'b0; seen_a = '0; seen_wd = '0; hs_ok = 1'b1;
        while (!rsp_valid && cyc < 40) begin
            if (mem_valid) begin
                saw = 1'b1; seen_a = mem_addr; seen_wd = mem_wdata;
                if (req_ready) hs_ok = 1'b0;
                for (int i = 0; i < stall; i++) begin
                    @(negedge clk); cyc++;
                    if (!mem_valid || mem_addr !== seen_a || req_ready) hs_ok = 1'b0;
                end
                mem_rdata = model_get(mem_addr);
                if (mem_write) mem_model[mem_addr] = mem_wdata;
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0; cyc++;
            end else begin
                @(negedge clk); cyc++;
            end
        end
        rd = rsp_data;
        if (req_ready) hs_ok = 1'b0;
        @(negedge clk);
        if (rsp_valid || !req_ready) hs_ok = 1'b0;
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 mem_valid", {63'd0, mem_valid}, 64'd0);
        reg_rd(2'd1, v); chk("R1 ctrl reset", {32'd0, v}, 64'h000C_0000);
        reg_rd(2'd2, v); chk("R1 base_lo reset", {32'd0, v}, 64'd0);
        reg_rd(2'd3, v); chk("R1 base_hi reset", {32'd0, v}, 64'd0);
    endtask

    task automatic t_capability;
        logic [31:0] v;
        reg_rd(2'd0, v); chk("R2 cap read", {32'd0, v}, 64'd1);
        reg_wr(2'd0, 32'h0000_0000);
        reg_rd(2'd0, v); chk("R2 cap after write", {32'd0, v}, 64'd1);
    endtask

    task automatic t_disabled;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        do_access(1'b0, 8'd0, 8'd0, 12'h010, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R6 disabled read data", {32'd0, rd}, 64'hFFFF_FFFF);
        chk("R6 disabled no mem", {63'd0, saw}, 64'd0);
        chk("R7 refusal latency", 64'(cyc), 64'd1);
        chk("R7 single pulse", {63'd0, ok}, 64'd1);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        reg_wr(2'd2, base[31:0]);
        reg_wr(2'd3, base[63:32]);
        reg_rd(2'd2, v); chk("R11 base_lo", {32'd0, v}, {32'd0, base[31:0]});
        reg_rd(2'd3, v); chk("R11 base_hi", {32'd0, v}, {32'd0, base[63:32]});
        reg_wr(2'd1, 32'hFFFF_FFFF);
        reg_rd(2'd1, v); chk("R10 ctrl all ones", {32'd0, v}, 64'h001F_0001);
        reg_wr(2'd1, 32'h0010_0001);
        reg_rd(2'd1, v); chk("R10 ctrl size16 en", {32'd0, v}, 64'h0010_0001);
    endtask

    task automatic t_root_valid;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        do_access(1'b0, 8'd0, 8'd0, 12'h010, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R3 root addr", a, exp_addr(8'd0, 8'd0, 12'h010));
        chk("R9 root read data", {32'd0, rd}, {32'd0, model_get(exp_addr(8'd0, 8'd0, 12'h010))});
        chk("R9 read latency", 64'(cyc), 64'd2);
        chk("R12 busy and pulse", {63'd0, ok}, 64'd1);
    endtask

    task automatic t_root_devfn;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        do_access(1'b0, 8'd0, 8'h08, 12'h000, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R4 root dev1 read no mem", {63'd0, saw}, 64'd0);
        chk("R4 root dev1 data", {32'd0, rd}, 64'hFFFF_FFFF);
        do_access(1'b1, 8'd0, 8'h01, 12'h000, 32'h1234_5678, 0, rd, saw, a, wd, cyc, ok);
        chk("R4 root fn1 write no mem", {63'd0, saw}, 64'd0);
        chk("R7 refused write latency", 64'(cyc), 64'd1);
    endtask

    task automatic t_link_gate;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        link_up = 1'b0;
        do_access(1'b0, 8'd1, 8'd0, 12'h004, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R5 link down read no mem", {63'd0, saw}, 64'd0);
        chk("R5 link down read data", {32'd0, rd}, 64'hFFFF_FFFF);
        do_access(1'b1, 8'd1, 8'd0, 12'h004, 32'hDEAD_BEEF, 0, rd, saw, a, wd, cyc, ok);
        chk("R8 link down write no mem", {63'd0, saw}, 64'd0);
        link_up = 1'b1;
        do_access(1'b0, 8'd1, 8'd0, 12'h004, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R5 link up reaches mem", {63'd0, saw}, 64'd1);
        chk("R8 dropped write left memory", {32'd0, rd},
            {32'd0, exp_addr(8'd1, 8'd0, 12'h004) ^ 64'hC0DE_0000} & 64'hFFFF_FFFF);
    endtask

    task automatic t_downstream_stall;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        link_up = 1'b1;
        do_access(1'b1, 8'd3, 8'h2A, 12'hFFC, 32'hA5A5_0F0F, 3, rd, saw, a, wd, cyc, ok);
        chk("R3 downstream write addr", a, exp_addr(8'd3, 8'h2A, 12'hFFC));
        chk("R9 write data passed", {32'd0, wd}, 64'hA5A5_0F0F);
        chk("R9 write rsp zero", {32'd0, rd}, 64'd0);
        chk("R9 stall hold", {63'd0, ok}, 64'd1);
        chk("R9 stalled latency", 64'(cyc), 64'd5);
        do_access(1'b0, 8'd3, 8'h2A, 12'hFFC, 32'd0, 2, rd, saw, a, wd, cyc, ok);
        chk("R9 read back written", {32'd0, rd}, 64'hA5A5_0F0F);
        do_access(1'b0, 8'hFF, 8'hFF, 12'hFFF, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R3 extreme fields carry", a, exp_addr(8'hFF, 8'hFF, 12'hFFF));
    endtask

    task automatic t_disable_again;
        logic [31:0] rd, wd; logic saw, ok; logic [63:0] a; int cyc;
        reg_wr(2'd1, 32'h0010_0000);
        do_access(1'b0, 8'd3, 8'h2A, 12'hFFC, 32'd0, 0, rd, saw, a, wd, cyc, ok);
        chk("R6 re-disabled no mem", {63'd0, saw}, 64'd0);
        chk("R6 re-disabled data", {32'd0, rd}, 64'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_capability();
        t_disabled();
        t_regs();
        t_root_valid();
        t_root_devfn();
        t_link_gate();
        t_downstream_stall();
        t_disable_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule